// File: doc/BRIEF.md
# Multi-device 8-bit peripheral bus sequencer

This block turns single register requests from inside the chip into complete read and write cycles on an 8-bit microcontroller-style bus. That bus serves up to three external peripheral chips. On the internal side a requester presents a device index, an 8-bit register address, write data and a direction, and raises a request strobe. The block returns read data together with a one-cycle completion pulse. On the external side it drives one active-low chip select per device, an address latch enable, active-low read and write strobes, a bidirectional address/data byte (split into output value, output enable and input value) and a dedicated address byte.

A mode input picks the bus layout. In multiplexed operation the address travels on the address/data lines while the latch enable is high. In demultiplexed operation those lines stay released during the address phase and the address is only on the dedicated address lines. The lengths of the address phase, the strobe and the hold phase are each a programmable number of clock cycles. The block also merges an active-low and an active-high interrupt input from the peripherals into a single synchronised request. It also provides a reset output for the attached chips.

Top module: `pbus_master`

## Requirements
- R1: During reset and in idle, all chip selects, the read strobe and the write strobe are high, the latch enable is low, and the address/data output enable is low.
- R2: A request is accepted only when `req_ready` is high, which is exactly when the block is idle. Device index d (0..2) drives `cs_n[d]` low, and only that select, for every cycle of the access up to the completion cycle. An index of 3 or more is rejected: no cycle is run and no completion pulse is given.
- R3: An access runs an address phase of S cycles with the latch enable high, then one gap cycle with the latch enable and both strobes inactive, then W cycles with the strobe low, then H hold cycles with the strobe high. S, W and H are `cfg_setup`, `cfg_strobe` and `cfg_hold`, and a programmed 0 counts as 1.
- R4: With `cfg_mux`=1 the address/data lines drive the address during the address phase. With `cfg_mux`=0 they are released then. In both modes `pa` carries the address for the whole access.
- R5: On a write (`req_write`=1), `wr_n` is low during the strobe phase, `rd_n` stays high, and the address/data lines drive the write data from the gap cycle through the last hold cycle.
- R6: On a read, `rd_n` is low during the strobe phase, `wr_n` stays high, and the address/data lines are released for the whole access. `rsp_rdata` holds the byte present on `ad_i` in the last strobe-low cycle.
- R7: `rsp_done` is high for exactly one cycle: the cycle after the last hold cycle, counted from the accepting edge as S+W+H+2 cycles. A request raised during a busy access is ignored.
- R8: `irq_req` equals (`irq0_n`==0) OR (`irq1`==1), delayed by a two-stage synchroniser. A change is visible after the second rising edge and not after the first.
- R9: `prst_n` is low during reset and goes high at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mux | input | 1 | 1 = multiplexed address/data, 0 = demultiplexed |
| cfg_setup | input | 4 | Address phase length in cycles (0 means 1) |
| cfg_strobe | input | 4 | Strobe width in cycles (0 means 1) |
| cfg_hold | input | 4 | Hold length in cycles (0 means 1) |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when idle and able to accept |
| req_dev | input | 2 | Device index |
| req_addr | input | 8 | Register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| cs_n | output | 3 | Active-low chip selects |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_o | output | 8 | Address/data output value |
| ad_oe | output | 1 | Address/data output enable |
| ad_i | input | 8 | Address/data input value |
| pa | output | 8 | Dedicated address lines |
| irq0_n | input | 1 | Active-low interrupt input |
| irq1 | input | 1 | Active-high interrupt input |
| irq_req | output | 1 | Merged, synchronised interrupt request |
| prst_n | output | 1 | Reset output to the peripherals |

## Verification
An accepted request affects the bus from the first cycle after the accepting edge. The completion pulse is due S+W+H+2 cycles after that edge, and the captured read byte is valid in that same cycle. The bench drives inputs on falling edges and samples each cycle on the falling edge. It classifies every cycle of an access as address, gap, strobe or hold phase and compares the counts with the programmed lengths, where 0 becomes 1. The merged interrupt is sampled after one rising edge, where the old value is expected, and again after the second edge, where the new value is due. The reset output is checked during reset and one edge after release.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_GAP,
    PH_STRB,
    PH_HOLD
  } pbus_phase_e;

  // Reload value for a down-counter so that a programmed length L lasts
  // max(L,1) cycles.
  function automatic logic [3:0] phase_reload(input logic [3:0] len);
    return (len == 4'd0) ? 4'd0 : len - 4'd1;
  endfunction

  // Index is legal when it names an existing device.
  function automatic logic dev_legal(input logic [1:0] dev, input int ndev);
    return ({30'd0, dev} < ndev);
  endfunction

endpackage

// File: rtl/pbus_csdec.sv
module pbus_csdec #(
  parameter int NDEV = 3,
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [IW-1:0] dev,
  output logic [NDEV-1:0] cs_n
);

  for (genvar g = 0; g < NDEV; g++) begin : g_sel
    assign cs_n[g] = !(active && (dev == IW'(g)));
  end

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // Selected device may not change while an access is underway.
  assert_cs_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cs_n));

endmodule

// File: rtl/pbus_irq.sv
module pbus_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_lo_n,
  input  logic irq_hi,
  output logic irq_req
);

  logic merged;
  logic sync1_q, sync2_q;

  assign merged = !irq_lo_n || irq_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= merged;
      sync2_q <= sync1_q;
    end
  end

  assign irq_req = sync2_q;

  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(!irq_lo_n || irq_hi, 2));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int NDEV = 3,
  parameter int DW   = 8,
  parameter int AW   = 8,
  localparam int IW  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mux,
  input  logic [3:0]    cfg_setup,
  input  logic [3:0]    cfg_strobe,
  input  logic [3:0]    cfg_hold,
  input  logic          req_valid,
  input  logic [IW-1:0] req_dev,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          idle,
  output logic          in_access,
  output logic [IW-1:0] dev,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  output logic [AW-1:0] pa
);

  pbus_phase_e   phase_q;
  logic [3:0]    cnt_q;
  logic [IW-1:0] dev_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  // Named events for assertions.
  logic accept, cnt_zero, strobe_phase, data_phase;

  assign cnt_zero     = (cnt_q == 4'd0);
  assign accept       = (phase_q == PH_IDLE) && req_valid &&
                        dev_legal({{(2-IW){1'b0}}, req_dev}, NDEV);
  assign strobe_phase = (phase_q == PH_STRB);
  assign data_phase   = (phase_q == PH_GAP) || (phase_q == PH_STRB) ||
                        (phase_q == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dev_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          dev_q   <= req_dev;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          cnt_q   <= phase_reload(cfg_setup);
          phase_q <= PH_ADDR;
        end
        PH_ADDR: begin
          if (cnt_zero) phase_q <= PH_GAP;
          else          cnt_q   <= cnt_q - 4'd1;
        end
        PH_GAP: begin
          cnt_q   <= phase_reload(cfg_strobe);
          phase_q <= PH_STRB;
        end
        PH_STRB: begin
          if (cnt_zero) begin
            if (!wr_q) rdata_q <= ad_i;
            cnt_q   <= phase_reload(cfg_hold);
            phase_q <= PH_HOLD;
          end else begin
            cnt_q <= cnt_q - 4'd1;
          end
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 4'd1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign idle      = (phase_q == PH_IDLE);
  assign in_access = !idle;
  assign dev       = dev_q;
  assign rsp_rdata = rdata_q;
  assign rsp_done  = done_q;
  assign ale       = (phase_q == PH_ADDR);
  assign rd_n      = !(strobe_phase && !wr_q);
  assign wr_n      = !(strobe_phase && wr_q);
  assign ad_oe     = (ale && cfg_mux) || (data_phase && wr_q);
  assign ad_o      = ale ? DW'(addr_q) : wdata_q;
  assign pa        = in_access ? addr_q : '0;

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_ale_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rd_n && wr_n && !ale && !ad_oe));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (rd_n && wr_n && !ale && !ad_oe));

endmodule

// File: rtl/pbus_master.sv
module pbus_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_mux,
  input  logic [3:0] cfg_setup,
  input  logic [3:0] cfg_strobe,
  input  logic [3:0] cfg_hold,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_dev,
  input  logic [7:0] req_addr,
  input  logic       req_write,
  input  logic [7:0] req_wdata,
  output logic [7:0] rsp_rdata,
  output logic       rsp_done,
  output logic [2:0] cs_n,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic [7:0] ad_o,
  output logic       ad_oe,
  input  logic [7:0] ad_i,
  output logic [7:0] pa,
  input  logic       irq0_n,
  input  logic       irq1,
  output logic       irq_req,
  output logic       prst_n
);

  localparam int NDEV = 3;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int IW   = $clog2(NDEV);

  logic          idle, in_access;
  logic [IW-1:0] sel_dev;
  logic          prst_q;

  pbus_seq #(.NDEV(NDEV), .DW(DW), .AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mux    (cfg_mux),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .cfg_hold   (cfg_hold),
    .req_valid  (req_valid),
    .req_dev    (req_dev),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .idle       (idle),
    .in_access  (in_access),
    .dev        (sel_dev),
    .rsp_rdata  (rsp_rdata),
    .rsp_done   (rsp_done),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ad_o       (ad_o),
    .ad_oe      (ad_oe),
    .ad_i       (ad_i),
    .pa         (pa)
  );

  pbus_csdec #(.NDEV(NDEV)) u_cs (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_access),
    .dev    (sel_dev),
    .cs_n   (cs_n)
  );

  pbus_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_lo_n (irq0_n),
    .irq_hi   (irq1),
    .irq_req  (irq_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prst_q <= 1'b0;
    else        prst_q <= 1'b1;
  end

  assign prst_n    = prst_q;
  assign req_ready = idle;

  assert_prst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> prst_n);

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n == 3'b111));

endmodule

// File: tb/sim_pbus_master.sv
`timescale 1ns/1ps
module sim_pbus_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_mux = 1'b1;
  logic [3:0] cfg_setup = 4'd1, cfg_strobe = 4'd1, cfg_hold = 4'd1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_dev = 2'd0;
  logic [7:0] req_addr = 8'd0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = 8'd0;
  logic [7:0] rsp_rdata;
  logic       rsp_done;
  logic [2:0] cs_n;
  logic       ale, rd_n, wr_n, ad_oe;
  logic [7:0] ad_o, ad_in, pa;
  logic       irq0_n = 1'b1, irq1 = 1'b0;
  logic       irq_req, prst_n;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Peripheral model: returns a byte derived from the address while read is low.
  always_comb ad_in = rd_n ? 8'h00 : (pa ^ 8'hA5);

  pbus_master u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .req_valid(req_valid),
    .req_ready(req_ready), .req_dev(req_dev), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_in), .pa(pa), .irq0_n(irq0_n),
    .irq1(irq1), .irq_req(irq_req), .prst_n(prst_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  // One access; optionally raise a second request with another device mid-way.
  task automatic access(input logic [1:0] dev, input logic [7:0] addr,
                        input logic [7:0] data, input bit wr, input bit poke);
    int n = 0, na = 0, ng = 0, ns = 0, nh = 0;
    bit cs_ok = 1, addr_ok = 1, data_ok = 1, pa_ok = 1, other_ok = 1, ready_ok = 1;
    logic [2:0] exp_cs;
    int exp_n;
    exp_cs = ~(3'b001 << dev);
    exp_n  = eff(cfg_setup) + 1 + eff(cfg_strobe) + eff(cfg_hold) + 1;
    @(negedge clk);
    req_dev = dev; req_addr = addr; req_wdata = data; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && n < 100) begin
      n++;
      if (cs_n != exp_cs) cs_ok = 0;
      if (pa != addr) pa_ok = 0;
      if (req_ready) ready_ok = 0;
      if (ale) begin
        na++;
        if (cfg_mux ? !(ad_oe && ad_o == addr) : ad_oe) addr_ok = 0;
      end else if (wr ? !wr_n : !rd_n) ns++;
      else if (ns == 0) ng++;
      else nh++;
      if (wr ? !rd_n : !wr_n) other_ok = 0;
      if (!ale && (wr ? !(ad_oe && ad_o == data) : ad_oe)) data_ok = 0;
      if (poke && n == 2) begin
        req_dev = (dev == 2'd0) ? 2'd1 : 2'd0; req_valid = 1'b1;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    n++;
    check(n == exp_n, "R7 done cycle", n, exp_n);
    check(na == eff(cfg_setup) && ng == 1, "R3 address+gap length", na, eff(cfg_setup));
    check(ns == eff(cfg_strobe), "R3 strobe length", ns, eff(cfg_strobe));
    check(nh == eff(cfg_hold), "R3 hold length", nh, eff(cfg_hold));
    check(cs_ok, "R2 chip select", int'(cs_n), int'(exp_cs));
    check(addr_ok && pa_ok, "R4 address lines", int'(pa), int'(addr));
    check(data_ok && other_ok, wr ? "R5 write data/strobe" : "R6 read release/strobe", 0, 1);
    check(ready_ok, "R2 ready while busy", 1, 0);
    if (!wr) check(rsp_rdata == (addr ^ 8'hA5), "R6 read data", int'(rsp_rdata), int'(addr ^ 8'hA5));
    @(negedge clk);
    check(!rsp_done, "R7 single done pulse", int'(rsp_done), 0);
    if (poke) begin
      for (int k = 0; k < 12; k++) begin
        check(!rsp_done && cs_n == 3'b111, "R7 busy request ignored", int'(cs_n), 7);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 3'b111 && rd_n && wr_n && !ale && !ad_oe, "R1 reset state", int'(cs_n), 7);
    check(!prst_n, "R9 reset output low in reset", int'(prst_n), 0);
    check(!rsp_done, "R1 no done in reset", int'(rsp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(prst_n, "R9 reset output released", int'(prst_n), 1);
    check(req_ready, "R1 idle ready", int'(req_ready), 1);

    // Sweep: mode x direction x device x lengths 0..2.
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 3; d++)
          for (int c = 0; c < 27; c++) begin
            cfg_mux = m[0];
            cfg_setup = 4'(c % 3); cfg_strobe = 4'((c / 3) % 3); cfg_hold = 4'(c / 9);
            access(2'(d), 8'(c * 9 + d * 77 + m * 5), 8'(c * 31 + w + 3), w[0], 1'b0);
          end

    // Longer phases and a request raised while busy.
    cfg_mux = 1'b1; cfg_setup = 4'd15; cfg_strobe = 4'd7; cfg_hold = 4'd4;
    access(2'd2, 8'h3C, 8'hC3, 1'b1, 1'b1);
    cfg_mux = 1'b0;
    access(2'd1, 8'hF0, 8'h00, 1'b0, 1'b1);

    // Illegal device index is rejected.
    @(negedge clk);
    req_dev = 2'd3; req_addr = 8'h11; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      check(cs_n == 3'b111 && !rsp_done && req_ready && rd_n && wr_n, "R2 index 3 rejected", int'(cs_n), 7);
      @(negedge clk);
    end

    // Interrupt merge, all input combinations, with latency.
    for (int t = 0; t < 8; t++) begin
      logic exp_old, exp_new;
      exp_old = irq_req;
      irq0_n = t[0]; irq1 = t[1] ^ t[2];
      exp_new = !irq0_n || irq1;
      @(negedge clk);
      check(irq_req == exp_old, "R8 interrupt not after one edge", int'(irq_req), int'(exp_old));
      @(negedge clk);
      check(irq_req == exp_new, "R8 interrupt merge", int'(irq_req), int'(exp_new));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule